// File: doc/BRIEF.md
# E1 Per-Timeslot Channel Data Router

This block routes the byte data of a 32-timeslot E1 frame in both directions. On the transmit side each timeslot byte comes from the system input, is registered, and goes out toward the line. On the receive side each line byte is registered and goes out to the system. A 5-bit control word per timeslot, written over a small write port, picks the source of each byte. A transmit byte can be the system byte, a byte from a processor-written message memory, the line byte received in the same timeslot, or a test byte. A system-output byte can be the line byte, the transmit system byte of the same timeslot, or a test byte.

One global select chooses the test source. With the select low, test timeslots carry bytes from an external PRBS generator reached through a request/response pair. Receive test timeslots hand their line byte to an external PRBS checker. With the select high, test timeslots carry an eight-byte tone pattern that repeats. The pattern steps once per use on each channel, so each channel sees one pattern byte per frame. The block also keeps the newest line byte of every timeslot, and the processor can read it combinationally.

Top module: `e1_slot_router`

## Requirements
- R1: After reset all control words are zero and no output strobe is active. With a zero control word, a system strobe produces a transmit strobe one clock later with the same slot and the same byte. A line strobe produces a system-output strobe one clock later with the same slot and byte.
- R2: Control bit 4 (message select), when bits 3 and 1 are clear, makes the transmit byte equal to the message memory entry for that slot. The processor writes that entry through the message port.
- R3: Control bit 3 (line-to-transmit loop) has the highest transmit priority. It sends the newest stored line byte of that slot.
- R4: Control bit 1 (transmit test) with bit 3 clear and the test select low raises `prbs_gen_req` in the same cycle as the system strobe. The transmit byte one clock later equals `prbs_gen_byte` as sampled in that cycle. This path takes precedence over message select.
- R5: Control bit 1 with bit 3 clear and the test select high transmits the tone pattern 0x34, 0x21, 0x21, 0x34, 0xB4, 0xA1, 0xA1, 0xB4, in that order and repeating.
- R6: Control bit 2 (system-to-output loop), when the tone replacement of R8 is inactive, makes the system-output byte equal to the newest system byte stored for that slot.
- R7: Control bit 0 (receive test) with the test select low raises `prbs_chk_vld` together with the system-output strobe. It presents the line byte on `prbs_chk_byte`. The system-output byte is left as R6 or R1 give it.
- R8: Control bit 0 with the test select high replaces the system-output byte with the tone pattern of R5. This replacement has priority over bit 2.
- R9: `cap_rdata` always shows the newest line byte received for slot `cap_addr`.
- R10: A control write changes only the addressed slot. If the write lands in the same cycle as a strobe for that slot, the strobe uses the old value. The new value applies from the next strobe of that slot.
- R11: Each slot has its own tone position in each direction, starting at the first pattern byte after reset. A position advances only when a tone byte is sent in that direction on that slot, and it wraps after eight bytes.
- R12: A loop source strobed in the same cycle and slot as its user is forwarded. R3 uses the line byte of that cycle, and R6 uses the system byte of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_addr | input | 5 | Slot of the control word |
| cfg_wdata | input | 5 | Control word: bit 4 message, bit 3 line loop, bit 2 system loop, bit 1 transmit test, bit 0 receive test |
| tst_sel | input | 1 | Test source: 0 PRBS, 1 tone pattern |
| msg_we | input | 1 | Message memory write strobe |
| msg_addr | input | 5 | Message memory slot |
| msg_wdata | input | 8 | Message byte |
| cap_addr | input | 5 | Slot to read from the capture memory |
| cap_rdata | output | 8 | Newest line byte of that slot |
| sys_in_vld | input | 1 | System byte strobe |
| sys_in_slot | input | 5 | Timeslot of the system byte |
| sys_in_data | input | 8 | System byte |
| line_in_vld | input | 1 | Line byte strobe |
| line_in_slot | input | 5 | Timeslot of the line byte |
| line_in_data | input | 8 | Line byte |
| tx_vld | output | 1 | Transmit byte strobe |
| tx_slot | output | 5 | Transmit timeslot |
| tx_data | output | 8 | Transmit byte |
| sys_out_vld | output | 1 | System-output strobe |
| sys_out_slot | output | 5 | System-output timeslot |
| sys_out_data | output | 8 | System-output byte |
| prbs_gen_req | output | 1 | Request for one generator byte |
| prbs_gen_byte | input | 8 | Generator byte, valid with the request |
| prbs_chk_vld | output | 1 | Checker byte strobe |
| prbs_chk_byte | output | 8 | Line byte for the checker |

## Verification
The bench goes through every slot with many control word mixes, in frames that strobe both directions, the system side only, or the line side only. If a design got the priorities wrong, a looped or test slot would show its message byte. A design without forwarding would loop a byte one frame old. A single shared tone counter would skip pattern bytes in a channel whenever another channel or the other direction used the tone. In one frame the control words are rewritten while that frame runs, both for the slot being strobed and for the next slot. A design that applied a write in the same cycle, or wrote to the wrong entry, would give wrong bytes in the next slot or in later frames.

// File: rtl/e1_slot_router.sv
module e1_slot_router #(
  parameter int SLOTS = 32,
  parameter int DW = 8,
  parameter int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_addr,
  input  logic [4:0]    cfg_wdata,
  input  logic          tst_sel,
  input  logic          msg_we,
  input  logic [SW-1:0] msg_addr,
  input  logic [DW-1:0] msg_wdata,
  input  logic [SW-1:0] cap_addr,
  output logic [DW-1:0] cap_rdata,
  input  logic          sys_in_vld,
  input  logic [SW-1:0] sys_in_slot,
  input  logic [DW-1:0] sys_in_data,
  input  logic          line_in_vld,
  input  logic [SW-1:0] line_in_slot,
  input  logic [DW-1:0] line_in_data,
  output logic          tx_vld,
  output logic [SW-1:0] tx_slot,
  output logic [DW-1:0] tx_data,
  output logic          sys_out_vld,
  output logic [SW-1:0] sys_out_slot,
  output logic [DW-1:0] sys_out_data,
  output logic          prbs_gen_req,
  input  logic [DW-1:0] prbs_gen_byte,
  output logic          prbs_chk_vld,
  output logic [DW-1:0] prbs_chk_byte
);
  localparam int C_MSG = 4;
  localparam int C_RLP = 3;
  localparam int C_SLP = 2;
  localparam int C_TTS = 1;
  localparam int C_RTS = 0;

  logic [4:0]    ctl     [SLOTS];
  logic [DW-1:0] msg_mem [SLOTS];
  logic [DW-1:0] cap_mem [SLOTS];
  logic [DW-1:0] lpb_mem [SLOTS];
  logic [2:0]    mw_tx   [SLOTS];
  logic [2:0]    mw_rx   [SLOTS];

  function automatic logic [7:0] tone(input logic [2:0] i);
    case (i[1:0])
      2'd0, 2'd3: tone = {i[2], 7'h34};
      default:    tone = {i[2], 7'h21};
    endcase
  endfunction

  logic          tx_loop, tx_test, tx_tone, rx_tone, rx_chk;
  logic [DW-1:0] rl_byte, ll_byte, tx_next, rx_next;

  assign tx_loop = ctl[sys_in_slot][C_RLP];
  assign tx_test = !tx_loop && ctl[sys_in_slot][C_TTS];
  assign tx_tone = tx_test && tst_sel;
  assign prbs_gen_req = sys_in_vld && tx_test && !tst_sel;
  assign rx_tone = ctl[line_in_slot][C_RTS] && tst_sel;
  assign rx_chk  = ctl[line_in_slot][C_RTS] && !tst_sel;

  assign rl_byte = (line_in_vld && line_in_slot == sys_in_slot) ? line_in_data : cap_mem[sys_in_slot];
  assign ll_byte = (sys_in_vld && sys_in_slot == line_in_slot) ? sys_in_data : lpb_mem[line_in_slot];
  assign cap_rdata = cap_mem[cap_addr];

  always_comb begin
    if (tx_loop)                      tx_next = rl_byte;
    else if (tx_test && !tst_sel)     tx_next = prbs_gen_byte;
    else if (tx_tone)                 tx_next = DW'(tone(mw_tx[sys_in_slot]));
    else if (ctl[sys_in_slot][C_MSG]) tx_next = msg_mem[sys_in_slot];
    else                              tx_next = sys_in_data;
  end

  always_comb begin
    if (rx_tone)                        rx_next = DW'(tone(mw_rx[line_in_slot]));
    else if (ctl[line_in_slot][C_SLP])  rx_next = ll_byte;
    else                                rx_next = line_in_data;
  end

  always_ff @(posedge clk) begin
    if (msg_we) msg_mem[msg_addr] <= msg_wdata;
    if (line_in_vld) cap_mem[line_in_slot] <= line_in_data;
    if (sys_in_vld) lpb_mem[sys_in_slot] <= sys_in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        ctl[i]   <= '0;
        mw_tx[i] <= '0;
        mw_rx[i] <= '0;
      end
      tx_vld        <= 1'b0;
      tx_slot       <= '0;
      tx_data       <= '0;
      sys_out_vld   <= 1'b0;
      sys_out_slot  <= '0;
      sys_out_data  <= '0;
      prbs_chk_vld  <= 1'b0;
      prbs_chk_byte <= '0;
    end else begin
      if (cfg_we) ctl[cfg_addr] <= cfg_wdata;
      if (sys_in_vld && tx_tone) mw_tx[sys_in_slot] <= mw_tx[sys_in_slot] + 3'd1;
      if (line_in_vld && rx_tone) mw_rx[line_in_slot] <= mw_rx[line_in_slot] + 3'd1;
      tx_vld <= sys_in_vld;
      if (sys_in_vld) begin
        tx_slot <= sys_in_slot;
        tx_data <= tx_next;
      end
      sys_out_vld  <= line_in_vld;
      prbs_chk_vld <= line_in_vld && rx_chk;
      if (line_in_vld) begin
        sys_out_slot  <= line_in_slot;
        sys_out_data  <= rx_next;
        prbs_chk_byte <= line_in_data;
      end
    end
  end
endmodule

module e1_slot_router_chk #(
  parameter int DW = 8,
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tst_sel,
  input logic          sys_in_vld,
  input logic [SW-1:0] sys_in_slot,
  input logic          line_in_vld,
  input logic [SW-1:0] line_in_slot,
  input logic [DW-1:0] line_in_data,
  input logic          tx_vld,
  input logic [SW-1:0] tx_slot,
  input logic [DW-1:0] tx_data,
  input logic          sys_out_vld,
  input logic [SW-1:0] sys_out_slot,
  input logic          prbs_gen_req,
  input logic [DW-1:0] prbs_gen_byte,
  input logic          prbs_chk_vld,
  input logic [DW-1:0] prbs_chk_byte
);
  p_tx_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n) tx_vld == $past(sys_in_vld));
  p_tx_slot_r1: assert property (@(posedge clk) disable iff (!rst_n) sys_in_vld |=> tx_slot == $past(sys_in_slot));
  p_rx_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n) sys_out_vld == $past(line_in_vld));
  p_rx_slot_r1: assert property (@(posedge clk) disable iff (!rst_n) line_in_vld |=> sys_out_slot == $past(line_in_slot));
  p_gen_cond_r4: assert property (@(posedge clk) disable iff (!rst_n) prbs_gen_req |-> sys_in_vld && !tst_sel);
  p_gen_take_r4: assert property (@(posedge clk) disable iff (!rst_n) prbs_gen_req |=> tx_data == $past(prbs_gen_byte));
  p_chk_cond_r7: assert property (@(posedge clk) disable iff (!rst_n) prbs_chk_vld |-> sys_out_vld && $past(!tst_sel));
  p_chk_byte_r7: assert property (@(posedge clk) disable iff (!rst_n) prbs_chk_vld |-> prbs_chk_byte == $past(line_in_data));
endmodule

bind e1_slot_router e1_slot_router_chk #(.DW(DW), .SW(SW)) u_chk (.*);

// File: tb/e1_slot_router_test.sv
`timescale 1ns/1ps
module e1_slot_router_test;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [4:0] cfg_addr = 0;
  logic [4:0] cfg_wdata = 0;
  logic tst_sel = 0;
  logic msg_we = 0;
  logic [4:0] msg_addr = 0;
  logic [7:0] msg_wdata = 0;
  logic [4:0] cap_addr = 0;
  logic [7:0] cap_rdata;
  logic sys_in_vld = 0;
  logic [4:0] sys_in_slot = 0;
  logic [7:0] sys_in_data = 0;
  logic line_in_vld = 0;
  logic [4:0] line_in_slot = 0;
  logic [7:0] line_in_data = 0;
  logic tx_vld, sys_out_vld, prbs_gen_req, prbs_chk_vld;
  logic [4:0] tx_slot, sys_out_slot;
  logic [7:0] tx_data, sys_out_data, prbs_chk_byte;
  logic [7:0] prbs_gen_byte;

  assign prbs_gen_byte = {3'b110, sys_in_slot};

  always #10 clk = ~clk;

  e1_slot_router uut (.*);

  int checks = 0;
  int fails = 0;

  logic [4:0] ctrl_m [32];
  logic [7:0] msg_m [32], cap_m [32], loop_m [32];
  int mwt [32], mwr [32];

  bit etx_v, erx_v, echk_v;
  logic [7:0] etx, erx, echk;
  logic [4:0] etx_s, erx_s;
  string ttag, rtag;
  string ov_tone = "";
  string ov_all = "";

  function automatic logic [7:0] mwb(input int i);
    case (i % 8)
      0: return 8'h34; 1: return 8'h21; 2: return 8'h21; 3: return 8'h34;
      4: return 8'hB4; 5: return 8'hA1; 6: return 8'hA1; default: return 8'hB4;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_pending();
    cmp(ttag, {31'd0, tx_vld}, {31'd0, etx_v}, "tx_vld");
    if (etx_v) begin
      cmp(ttag, {27'd0, tx_slot}, {27'd0, etx_s}, "tx_slot");
      cmp(ttag, {24'd0, tx_data}, {24'd0, etx}, "tx_data");
    end
    cmp(rtag, {31'd0, sys_out_vld}, {31'd0, erx_v}, "sys_out_vld");
    cmp("R7", {31'd0, prbs_chk_vld}, {31'd0, echk_v}, "prbs_chk_vld");
    if (erx_v) begin
      cmp(rtag, {27'd0, sys_out_slot}, {27'd0, erx_s}, "sys_out_slot");
      cmp(rtag, {24'd0, sys_out_data}, {24'd0, erx}, "sys_out_data");
    end
    if (echk_v) cmp("R7", {24'd0, prbs_chk_byte}, {24'd0, echk}, "prbs_chk_byte");
  endtask

  task automatic step(input bit ds, input bit dl, input int s, input int fr,
                      input bit we, input int wa, input logic [4:0] wv);
    logic [4:0] c;
    logic [7:0] sb, lb;
    bit ereq;
    @(negedge clk);
    check_pending();
    sb = 8'((fr * 37 + s * 5 + 1));
    lb = 8'((fr * 53 + s * 11 + 7)) ^ 8'h5A;
    sys_in_vld = ds; sys_in_slot = 5'(s); sys_in_data = sb;
    line_in_vld = dl; line_in_slot = 5'(s); line_in_data = lb;
    cfg_we = we; cfg_addr = 5'(wa); cfg_wdata = wv;
    ereq = 0;
    etx_v = ds; etx_s = 5'(s); erx_v = dl; erx_s = 5'(s); echk_v = 0;
    c = ctrl_m[s];
    if (ds) begin
      if (c[3]) begin etx = dl ? lb : cap_m[s]; ttag = dl ? "R12" : "R3"; end
      else if (c[1] && !tst_sel) begin etx = {3'b110, 5'(s)}; ttag = "R4"; ereq = 1; end
      else if (c[1]) begin etx = mwb(mwt[s]); mwt[s]++; ttag = (ov_tone != "") ? ov_tone : "R5"; end
      else if (c[4]) begin etx = msg_m[s]; ttag = "R2"; end
      else begin etx = sb; ttag = "R1"; end
      if (ov_all != "") ttag = ov_all;
    end
    if (dl) begin
      echk_v = c[0] && !tst_sel; echk = lb;
      if (c[0] && tst_sel) begin erx = mwb(mwr[s]); mwr[s]++; rtag = (ov_tone != "") ? ov_tone : "R8"; end
      else if (c[2]) begin erx = ds ? sb : loop_m[s]; rtag = ds ? "R12" : "R6"; end
      else begin erx = lb; rtag = "R1"; end
      if (ov_all != "") rtag = ov_all;
    end
    if (dl) cap_m[s] = lb;
    if (ds) loop_m[s] = sb;
    if (we) ctrl_m[wa] = wv;
    #1;
    cmp("R4", {31'd0, prbs_gen_req}, {31'd0, ereq}, "prbs_gen_req");
  endtask

  task automatic idle();
    @(negedge clk);
    check_pending();
    sys_in_vld = 0; line_in_vld = 0; cfg_we = 0; msg_we = 0;
    etx_v = 0; erx_v = 0; echk_v = 0;
  endtask

  task automatic frame(input bit ds, input bit dl, input int fr);
    for (int s = 0; s < 32; s++) step(ds, dl, s, fr, 0, 0, 5'd0);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      ctrl_m[i] = 0; mwt[i] = 0; mwr[i] = 0; cap_m[i] = 0; loop_m[i] = 0; msg_m[i] = 0;
    end
    etx_v = 0; erx_v = 0; echk_v = 0; ttag = "R1"; rtag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1", {28'd0, tx_vld, sys_out_vld, prbs_gen_req, prbs_chk_vld}, 32'd0, "strobes in reset");
    rst_n = 1;
    idle();
    frame(1, 1, 0);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      msg_we = 1; msg_addr = 5'(i); msg_wdata = 8'(i * 29 + 100); msg_m[i] = 8'(i * 29 + 100);
    end
    idle();
    for (int i = 0; i < 32; i++) step(0, 0, i, 0, 1, i, 5'((i * 13 + 5) % 32));
    idle();
    for (int f = 1; f <= 3; f++) frame(1, 1, f);
    @(negedge clk); tst_sel = 1;
    for (int f = 4; f <= 13; f++) frame(1, 1, f);
    ov_tone = "R11";
    frame(1, 0, 14);
    frame(0, 1, 15);
    frame(1, 1, 16);
    ov_tone = "";
    @(negedge clk); tst_sel = 0;
    ov_all = "R10";
    for (int s = 0; s < 32; s++) begin
      int wa;
      wa = (s % 2 == 0) ? s : (s + 1) % 32;
      step(1, 1, s, 17, 1, wa, 5'((s * 7 + 11) % 32));
    end
    idle();
    frame(1, 1, 18);
    ov_all = "";
    @(negedge clk); tst_sel = 1;
    frame(1, 1, 19);
    frame(1, 1, 20);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      cap_addr = 5'(i);
      #1;
      cmp("R9", {24'd0, cap_rdata}, {24'd0, cap_m[i]}, "cap_rdata");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule